// File: doc/BRIEF.md
# Response Frame Serializer

This block turns a short command (an opcode, a 16-bit block count and a block size of 0 to 3 bytes) into a complete response frame and hands it, one byte at a time, to a serial transmitter over a valid/ready byte handshake. A frame consists of a five-byte header, a payload read from a sample memory, and a single trailing check byte. The payload is as long as the block count times the block size, so a frame can be anywhere from a handful of bytes up to 65541 bytes. The payload is never held in the block: it is streamed straight out of the memory.

The memory is reached through a synchronous read port with one cycle of latency. The block issues each read ahead of time into a two-entry prefetch buffer. While the transmitter keeps ready high, payload bytes therefore leave at one per cycle. When ready drops, nothing is lost or sent twice. The command is captured on a start pulse, and the busy flag covers the whole frame. A payload that would exceed 65535 bytes is cut to that length and flagged. An optional minimum-length rule pads an empty payload with a single filler byte for receivers that expect at least one data byte.

Top module: `rsp_frame_ser`

## Requirements
- R1: After reset, busy_o, err_o, tx_valid_o and ram_rd_en_o are all low.
- R2: The frame opens with five header bytes in this order: the opcode, the constant 0xEF, the high byte of the block count, the low byte of the block count, and the block size zero-extended to 8 bits.
- R3: Following the header, the payload holds exactly count × size bytes. Payload byte k is the memory word at address k, taken in increasing k. With opcode 0xBE, count 3, size 2 and memory bytes 00 01 00 02 00 03, the frame is BE EF 00 03 02 00 01 00 02 00 03 FF.
- R4: Every frame ends with the check byte 0xFF.
- R5: A start pulse is accepted only while busy_o is low. busy_o is high from the cycle after an accepted start until the cycle after the check byte is accepted. A start pulse or an input change during a frame has no effect on that frame and starts no later frame.
- R6: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o keeps its value in the next cycle. Under any ready pattern, every frame byte is delivered exactly once.
- R7: If count × size exceeds 65535, the payload is 65535 bytes long. In that case err_o is high from the cycle after the start until the next accepted start. Otherwise err_o is low for that frame.
- R8: With the default parameters, a block count of 0 or a block size of 0 produces a 6-byte frame (header plus check byte) and no memory read.
- R9: With MIN_LEN_EN set, an empty payload is replaced by one filler byte 0x00 and no memory is read, giving a 7-byte frame.
- R10: Each payload address is read exactly once, starting at 0 and rising by one, and no address at or above the payload length is read. Read data is taken in the cycle after ram_rd_en_o.
- R11: With tx_ready_i held high, the frame's bytes are accepted in consecutive cycles with no gap, including across the header-to-payload boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to send a frame |
| opcode_i | input | 8 | Opcode placed in header byte 0 |
| blk_cnt_i | input | 16 | Number of payload blocks |
| blk_size_i | input | 2 | Bytes per block (0 to 3) |
| busy_o | output | 1 | Frame in progress |
| err_o | output | 1 | Payload length was clamped to 65535 |
| ram_rd_en_o | output | 1 | Memory read strobe |
| ram_addr_o | output | 16 | Memory byte address |
| ram_rdata_i | input | 8 | Memory read data, valid one cycle after the strobe |
| tx_valid_o | output | 1 | Byte offered to the transmitter |
| tx_data_o | output | 8 | Byte value |
| tx_ready_i | input | 1 | Transmitter accepts the byte this cycle |

## Verification
The hard case is a cycle in which the transmitter takes a payload byte out of the prefetch buffer while a memory read is also being issued and the data of the previous read is landing in the buffer. Both the occupancy arithmetic and the address counter must hold up there. This is provoked by driving ready from a pseudo-random pattern over a frame several hundred bytes long, with memory contents that differ at every address. It is judged by comparing the captured byte stream against a model built from the memory function, by checking that every memory address is read in strict order exactly once, and by confirming that no offered byte changed or vanished while ready was low.

// File: rtl/rsp_ser_pkg.sv
package rsp_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2,
        ST_CHK  = 2'd3
    } ser_state_e;

    localparam int HDR_BYTES = 5;

endpackage

// File: rtl/rsp_len_calc.sv
module rsp_len_calc #(
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 2,
    parameter int LEN_W  = 16
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [LEN_W-1:0]  len_o,
    output logic              clamp_o
);
    localparam int PROD_W = CNT_W + SIZE_W;

    logic [PROD_W-1:0] prod;
    assign prod = PROD_W'(cnt_i) * PROD_W'(size_i);

    generate
        if (PROD_W > LEN_W) begin : g_clamp
            localparam logic [PROD_W-1:0] LIM =
                {{(PROD_W-LEN_W){1'b0}}, {LEN_W{1'b1}}};
            always_comb begin
                clamp_o = (prod > LIM);
                len_o   = clamp_o ? {LEN_W{1'b1}} : prod[LEN_W-1:0];
            end
        end else begin : g_fit
            always_comb begin
                clamp_o = 1'b0;
                len_o   = LEN_W'(prod);
            end
        end
    endgenerate

endmodule

// File: rtl/rsp_prefetch_fifo.sv
module rsp_prefetch_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     dout_o,
    output logic [OCC_W-1:0] occ_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [OCC_W-1:0] occ;
    } fifo_regs_t;

    fifo_regs_t       q, d;
    logic [W-1:0]     mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (push_i) d.wr = nxt(q.wr);
        if (pop_i)  d.rd = nxt(q.rd);
        d.occ = q.occ + OCC_W'(push_i) - OCC_W'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[q.wr] <= din_i;
    end

    assign dout_o = mem_q[q.rd];
    assign occ_o  = q.occ;

endmodule

// File: rtl/rsp_frame_ser.sv
module rsp_frame_ser
    import rsp_ser_pkg::*;
#(
    parameter int         SIZE_W     = 2,
    parameter int         LEN_W      = 16,
    parameter int         ADDR_W     = 16,
    parameter logic [7:0] MARKER     = 8'hEF,
    parameter logic [7:0] CHECK_BYTE = 8'hFF,
    parameter logic [7:0] PAD_BYTE   = 8'h00,
    parameter bit         MIN_LEN_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [15:0]       blk_cnt_i,
    input  logic [SIZE_W-1:0] blk_size_i,
    output logic              busy_o,
    output logic              err_o,
    output logic              ram_rd_en_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    input  logic [7:0]        ram_rdata_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    input  logic              tx_ready_i
);
    localparam int CNT_W  = 16;
    localparam int FDEPTH = 2;
    localparam int OCC_W  = $clog2(FDEPTH + 1);
    localparam int IDX_W  = $clog2(HDR_BYTES);

    typedef struct packed {
        ser_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [7:0]        op;
        logic [CNT_W-1:0]  cnt;
        logic [SIZE_W-1:0] size;
        logic [LEN_W-1:0]  rd_left;
        logic [LEN_W-1:0]  tx_left;
        logic [ADDR_W-1:0] addr;
        logic              pend;
        logic              err;
        logic              pad;
    } ser_regs_t;

    ser_regs_t q, d;

    logic [LEN_W-1:0]  len;
    logic              clamp;
    logic [7:0]        f_dout;
    logic [OCC_W-1:0]  f_occ;
    logic              pop;
    logic              issue;
    logic              acc;
    logic [7:0]        hdr_byte;
    logic [OCC_W:0]    occ_next;
    logic              empty_pl;

    rsp_len_calc #(
        .CNT_W  (CNT_W),
        .SIZE_W (SIZE_W),
        .LEN_W  (LEN_W)
    ) u_len (
        .cnt_i   (blk_cnt_i),
        .size_i  (blk_size_i),
        .len_o   (len),
        .clamp_o (clamp)
    );

    rsp_prefetch_fifo #(
        .W     (8),
        .DEPTH (FDEPTH)
    ) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (q.pend),
        .din_i  (ram_rdata_i),
        .pop_i  (pop),
        .dout_o (f_dout),
        .occ_o  (f_occ)
    );

    // Header byte selection
    always_comb begin
        case (q.idx)
            IDX_W'(0): hdr_byte = q.op;
            IDX_W'(1): hdr_byte = MARKER;
            IDX_W'(2): hdr_byte = q.cnt[CNT_W-1 -: 8];
            IDX_W'(3): hdr_byte = q.cnt[7:0];
            default:   hdr_byte = 8'(q.size);
        endcase
    end

    // Output stage, driven from registers only
    always_comb begin
        tx_valid_o = 1'b0;
        tx_data_o  = 8'h00;
        case (q.st)
            ST_HDR: begin
                tx_valid_o = 1'b1;
                tx_data_o  = hdr_byte;
            end
            ST_PAY: begin
                tx_valid_o = q.pad || (f_occ != '0);
                tx_data_o  = q.pad ? PAD_BYTE : f_dout;
            end
            ST_CHK: begin
                tx_valid_o = 1'b1;
                tx_data_o  = CHECK_BYTE;
            end
            default: ;
        endcase
    end

    assign acc      = tx_valid_o && tx_ready_i;
    assign pop      = (q.st == ST_PAY) && !q.pad && acc;
    assign occ_next = (OCC_W+1)'(f_occ) + (OCC_W+1)'(q.pend) - (OCC_W+1)'(pop);
    assign issue    = (q.st != ST_IDLE) && (q.rd_left != '0)
                      && (occ_next < (OCC_W+1)'(FDEPTH));
    assign empty_pl = (len == '0);

    // Next-state computation
    always_comb begin
        d      = q;
        d.pend = issue;
        if (issue) begin
            d.addr    = q.addr + 1'b1;
            d.rd_left = q.rd_left - 1'b1;
        end
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_HDR;
                    d.idx  = '0;
                    d.op   = opcode_i;
                    d.cnt  = blk_cnt_i;
                    d.size = blk_size_i;
                    d.addr = '0;
                    d.err  = clamp;
                    d.pad  = MIN_LEN_EN && empty_pl;
                    d.rd_left = len;
                    d.tx_left = (MIN_LEN_EN && empty_pl) ? LEN_W'(1) : len;
                end
            end
            ST_HDR: begin
                if (acc) begin
                    if (q.idx == IDX_W'(HDR_BYTES - 1))
                        d.st = (q.tx_left != '0) ? ST_PAY : ST_CHK;
                    else
                        d.idx = q.idx + 1'b1;
                end
            end
            ST_PAY: begin
                if (acc) begin
                    d.tx_left = q.tx_left - 1'b1;
                    if (q.tx_left == LEN_W'(1)) d.st = ST_CHK;
                end
            end
            ST_CHK: begin
                if (acc) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st != ST_IDLE);
    assign err_o       = q.err;
    assign ram_rd_en_o = issue;
    assign ram_addr_o  = q.addr;

endmodule

// File: rtl/rsp_frame_ser_chk.sv
module rsp_frame_ser_chk #(
    parameter int         ADDR_W     = 16,
    parameter logic [7:0] CHECK_BYTE = 8'hFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              err_o,
    input logic              ram_rd_en_o,
    input logic [ADDR_W-1:0] ram_addr_o,
    input logic              tx_valid_o,
    input logic [7:0]        tx_data_o,
    input logic              tx_ready_i
);
    logic [ADDR_W-1:0] exp_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                  exp_addr_q <= '0;
        else if (start_i && !busy_o) exp_addr_q <= '0;
        else if (ram_rd_en_o)        exp_addr_q <= exp_addr_q + 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (!tx_valid_o && !ram_rd_en_o)); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R5
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R6
    AST_ERR_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && $past(busy_o)) |-> $stable(err_o)); // R7
    AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n) ram_rd_en_o |-> (ram_addr_o == exp_addr_q)); // R10
    AST_END_CHECK: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> $past(tx_valid_o && tx_ready_i && (tx_data_o == CHECK_BYTE))); // R4

endmodule

bind rsp_frame_ser rsp_frame_ser_chk #(
    .ADDR_W     (ADDR_W),
    .CHECK_BYTE (CHECK_BYTE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .ram_rd_en_o (ram_rd_en_o),
    .ram_addr_o  (ram_addr_o),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .tx_ready_i  (tx_ready_i)
);

// File: tb/rsp_frame_ser_bench.sv
`timescale 1ns/1ps
module rsp_frame_ser_bench;

    localparam int WATCHDOG = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        start_p = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [15:0] blk_cnt_i = 16'h0;
    logic [1:0]  blk_size_i = 2'd0;
    logic        busy_o, err_o, ram_rd_en_o, tx_valid_o;
    logic [15:0] ram_addr_o;
    logic [7:0]  ram_rdata_i = 8'h00;
    logic [7:0]  tx_data_o;
    logic        tx_ready_i = 1'b0;

    logic        p_busy, p_err, p_rd_en, p_valid;
    logic [15:0] p_addr;
    logic [7:0]  p_data;

    always #4 clk = ~clk;

    rsp_frame_ser u_rsp_frame_ser (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .blk_cnt_i(blk_cnt_i), .blk_size_i(blk_size_i), .busy_o(busy_o),
        .err_o(err_o), .ram_rd_en_o(ram_rd_en_o), .ram_addr_o(ram_addr_o),
        .ram_rdata_i(ram_rdata_i), .tx_valid_o(tx_valid_o),
        .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i)
    );

    rsp_frame_ser #(.MIN_LEN_EN(1'b1)) u_rsp_frame_ser_pad (
        .clk(clk), .rst_n(rst_n), .start_i(start_p), .opcode_i(opcode_i),
        .blk_cnt_i(blk_cnt_i), .blk_size_i(blk_size_i), .busy_o(p_busy),
        .err_o(p_err), .ram_rd_en_o(p_rd_en), .ram_addr_o(p_addr),
        .ram_rdata_i(8'h5A), .tx_valid_o(p_valid),
        .tx_data_o(p_data), .tx_ready_i(1'b1)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit ram_mode = 1'b0;
    bit rdy_rand = 1'b0;
    logic [7:0] lfsr = 8'hA7;

    logic [7:0] rx_q[$];
    logic [7:0] rx_p[$];
    int rd_count, p_rd_count, addr_err, stall_viol;
    int first_acc, last_acc, fall_cyc;
    logic [15:0] exp_addr;
    bit prev_stall, busy_d1;
    logic [7:0] prev_data;

    function automatic logic [7:0] ram_byte(input logic [15:0] a, input bit mode);
        if (!mode) return a[0] ? (a[8:1] + 8'd1) : 8'h00;
        return (a[7:0] * 8'd7 + 8'd3) ^ a[15:8];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h), expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    // Ready pattern
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready_i <= rdy_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    // Memory model and monitors
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ram_rd_en_o) begin
            ram_rdata_i <= ram_byte(ram_addr_o, ram_mode);
            if (ram_addr_o != exp_addr) addr_err++;
            exp_addr++;
            rd_count++;
        end
        if (p_rd_en) p_rd_count++;
        if (p_valid) rx_p.push_back(p_data);
        if (prev_stall && (!tx_valid_o || tx_data_o != prev_data)) stall_viol++;
        prev_stall = tx_valid_o && !tx_ready_i;
        prev_data  = tx_data_o;
        if (tx_valid_o && tx_ready_i) begin
            rx_q.push_back(tx_data_o);
            if (first_acc < 0) first_acc = cyc;
            last_acc = cyc;
        end
        if (!busy_o && busy_d1) fall_cyc = cyc;
        busy_d1 = busy_o;
    end

    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            n_fail++;
            n_chk++;
            $display("FAIL R5 watchdog: cycle %0d reached, expected completion before %0d",
                     cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] exp_byte(input int i, input int n,
            input logic [7:0] op, input logic [15:0] cnt, input logic [1:0] sz,
            input bit mode);
        if (i == 0) return op;
        if (i == 1) return 8'hEF;
        if (i == 2) return cnt[15:8];
        if (i == 3) return cnt[7:0];
        if (i == 4) return {6'b0, sz};
        if (i == n - 1) return 8'hFF;
        return ram_byte(16'(i - 5), mode);
    endfunction

    task automatic run_frame(input logic [7:0] op, input logic [15:0] cnt,
                             input logic [1:0] sz, input bit mode, input bit rnd,
                             input bit poke, input bit exp_err);
        int p, n, bad;
        bit late_busy;
        p = int'(cnt) * int'(sz);
        if (p > 65535) p = 65535;
        n = p + 6;
        @(negedge clk);
        rx_q.delete();
        rd_count = 0; addr_err = 0; stall_viol = 0; exp_addr = 16'h0;
        first_acc = -1; last_acc = -1; fall_cyc = -1;
        ram_mode = mode; rdy_rand = rnd;
        start_i = 1'b1; opcode_i = op; blk_cnt_i = cnt; blk_size_i = sz;
        @(negedge clk);
        start_i = 1'b0; opcode_i = 8'hA5; blk_cnt_i = 16'h0007; blk_size_i = 2'd1;
        check(busy_o == 1'b1, "R5", "busy after start", busy_o, 1);
        if (poke) begin
            repeat (8) @(negedge clk);
            start_i = 1'b1; opcode_i = 8'h11;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        late_busy = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (busy_o) late_busy = 1'b1;
        end
        rdy_rand = 1'b0;
        check(rx_q.size() == n, "R3", "frame length", rx_q.size(), n);
        bad = -1;
        for (int i = 0; i < rx_q.size() && i < n; i++)
            if (bad < 0 && rx_q[i] != exp_byte(i, n, op, cnt, sz, mode)) bad = i;
        if (bad < 0)
            check(1'b1, "R3", "frame bytes", 0, 0);
        else if (bad < 5)
            check(1'b0, "R2", $sformatf("header byte %0d", bad), rx_q[bad],
                  exp_byte(bad, n, op, cnt, sz, mode));
        else if (bad == n - 1)
            check(1'b0, "R4", "check byte", rx_q[bad], 8'hFF);
        else
            check(1'b0, "R3", $sformatf("payload byte %0d", bad - 5), rx_q[bad],
                  exp_byte(bad, n, op, cnt, sz, mode));
        check(err_o == exp_err, "R7", "error flag", err_o, exp_err);
        check(rd_count == p && addr_err == 0, "R10", "memory reads (count, order errors in act high bits)",
              longint'(rd_count) + (longint'(addr_err) << 32), p);
        check(stall_viol == 0, "R6", "held byte changed under back-pressure", stall_viol, 0);
        check(fall_cyc == last_acc + 1, "R5", "busy fall cycle", fall_cyc, last_acc + 1);
        if (!rnd)
            check(last_acc - first_acc + 1 == n, "R11", "cycles spanned by frame",
                  last_acc - first_acc + 1, n);
        if (poke)
            check(!late_busy, "R5", "frame started by ignored start", late_busy, 0);
    endtask

    task automatic t_reset;
        check(!busy_o && !err_o && !tx_valid_o && !ram_rd_en_o, "R1",
              "reset outputs {busy,err,valid,rd}",
              {busy_o, err_o, tx_valid_o, ram_rd_en_o}, 0);
    endtask

    task automatic t_example;
        logic [7:0] ref_f [12] = '{8'hBE, 8'hEF, 8'h00, 8'h03, 8'h02, 8'h00,
                                   8'h01, 8'h00, 8'h02, 8'h00, 8'h03, 8'hFF};
        int bad;
        run_frame(8'hBE, 16'h0003, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        bad = -1;
        for (int i = 0; i < 12 && i < rx_q.size(); i++)
            if (bad < 0 && rx_q[i] != ref_f[i]) bad = i;
        check(bad < 0 && rx_q.size() == 12, "R3", "example frame first bad index",
              bad, -1);
    endtask

    task automatic t_backpressure;
        run_frame(8'h3C, 16'h0105, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_size_one;
        run_frame(8'h81, 16'h0A02, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_zero_payload;
        run_frame(8'h42, 16'h0000, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);   // R8 count 0
        run_frame(8'h43, 16'h0005, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);   // R8 size 0
    endtask

    task automatic t_start_while_busy;
        run_frame(8'h5D, 16'h0100, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_clamp;
        run_frame(8'h77, 16'h8000, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1);   // R7 clamp
        run_frame(8'h78, 16'h0004, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);   // R7 clears
    endtask

    task automatic t_pad;
        rx_p.delete();
        p_rd_count = 0;
        @(negedge clk);
        start_p = 1'b1; opcode_i = 8'h90; blk_cnt_i = 16'h0000; blk_size_i = 2'd3;
        @(negedge clk);
        start_p = 1'b0;
        while (p_busy) @(negedge clk);
        check(rx_p.size() == 7, "R9", "padded frame length", rx_p.size(), 7);
        if (rx_p.size() == 7) begin
            check(rx_p[5] == 8'h00, "R9", "filler byte", rx_p[5], 0);
            check(rx_p[6] == 8'hFF, "R4", "padded check byte", rx_p[6], 8'hFF);
        end
        check(p_rd_count == 0, "R9", "reads for filler", p_rd_count, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_example();
        t_backpressure();
        t_size_one();
        t_zero_payload();
        t_start_while_busy();
        t_clamp();
        t_pad();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule